// File: doc/BRIEF.md
# Presettable Down Counter with Zero Detect

This block is a synchronous down counter whose width is built from four-bit digits. A compile-time parameter picks the arithmetic. In binary mode the register counts as one plain number. In decade mode each nibble is a BCD digit that wraps from 0 to 9 and borrows from the next digit up. With the default of two digits, the counter is eight bits wide. It holds 255 at most in binary mode and 99 in decade mode.

Four active-low controls steer it, in strict priority: clear-to-maximum, immediate preset, clocked preset, and count enable. Clear and immediate preset act on the visible count in the same cycle, without waiting for a clock edge. Clocked preset loads the preset word at the next rising edge. The count enable lets the counter step down by one on each rising edge. The active-low zero flag is combinational. Counters sharing one clock can therefore be chained by driving each stage's enable from the previous stage's zero flag. A synchronous active-high reset returns the count to the maximum.

Top module: `pdc_counter`

## Requirements
- R1: With clr_n, apre_n and spre_n high and cen_n low, each rising edge lowers the count by one. In binary mode this is plain subtraction modulo 2^W.
- R2: With all four controls high, the count holds across clock edges.
- R3: While clr_n is low, value equals the maximum (255 binary, 0x99 decade at default size) at once, whatever the other inputs are. The count stays at the maximum after clr_n is released.
- R4: While apre_n is low and clr_n is high, value equals jam at once, whatever spre_n, cen_n and the clock do. A pulse that spans a rising edge leaves jam in the count.
- R5: With clr_n and apre_n high and spre_n low, the next rising edge loads jam, whether cen_n is high or low.
- R6: Priority from highest to lowest is clr_n, apre_n, spre_n, cen_n.
- R7: zero_n is low exactly when value is zero and cen_n is low. It follows both inputs in the same cycle.
- R8: An enabled count at zero goes to the maximum on the next edge. A free-running count reaches zero 255 edges after the maximum in binary mode and 99 edges after it in decade mode, and returns to the maximum after 256 and 100 edges.
- R9: In decade mode, jam[7:4] is the upper digit and jam[3:0] the lower digit, with bit 3 of each nibble as its MSB. The lower digit wraps 0 to 9 and borrows. The upper digit steps down only when the lower digit is 0 (0x10 becomes 0x09).
- R10: In decade mode, a jam word with digits above 9 is loaded as given. From 0xFF, the count reads 0xA0 after 65 enabled edges and the valid value 0x99 after 66.
- R11: A high rst at a rising edge sets the count to the maximum.
- R12: When one stage's cen_n is driven by another stage's zero_n, the second stage steps down exactly once, on the edge where the first stage wraps from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to maximum |
| clr_n | input | 1 | Active-low clear to maximum, immediate |
| apre_n | input | 1 | Active-low immediate preset from jam |
| spre_n | input | 1 | Active-low clocked preset from jam |
| cen_n | input | 1 | Active-low count enable / carry in |
| jam | input | W (8) | Preset word |
| value | output | W (8) | Visible count |
| zero_n | output | 1 | Active-low zero detect / carry out |

## Verification
Clear, immediate preset and the zero flag act in the same cycle as their input change. The bench therefore checks them 1 ns after driving the input, with no clock edge in between. Counting, hold, clocked preset, wrap and reset take effect exactly one rising edge later. All inputs change on falling edges, and those results are sampled at the following falling edge. The period, invalid-digit and cascade tests count edges one by one and compare the result at the exact edge number the requirement gives.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic {CNT_BIN = 1'b0, CNT_BCD = 1'b1} cnt_mode_e;

  // largest count for the chosen arithmetic and digit count
  function automatic logic [63:0] max_count(cnt_mode_e mode, int digits);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < digits; i++) begin
      r[i*4 +: 4] = (mode == CNT_BCD) ? 4'd9 : 4'hF;
    end
    return r;
  endfunction
endpackage

// File: rtl/pdc_decade.sv
module pdc_decade (
  input  logic [3:0] d,
  input  logic       bin,
  output logic [3:0] q,
  output logic       bout
);
  always_comb begin
    bout = bin && (d == 4'd0);
    if (!bin)            q = d;
    else if (d == 4'd0)  q = 4'd9;
    else                 q = d - 4'd1;
  end
endmodule

// File: rtl/pdc_step.sv
module pdc_step
  import pdc_pkg::*;
#(
  parameter cnt_mode_e MODE   = CNT_BIN,
  parameter int        DIGITS = 2,
  localparam int       W      = 4 * DIGITS
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  generate
    if (MODE == CNT_BIN) begin : g_bin
      assign nxt = cur - ONE;
    end else begin : g_bcd
      logic [DIGITS:0] borrow;
      assign borrow[0] = 1'b1;
      for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        pdc_decade u_dec (
          .d    (cur[i*4 +: 4]),
          .bin  (borrow[i]),
          .q    (nxt[i*4 +: 4]),
          .bout (borrow[i+1])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/pdc_counter.sv
module pdc_counter
  import pdc_pkg::*;
#(
  parameter cnt_mode_e MODE   = CNT_BIN,
  parameter int        DIGITS = 2,
  localparam int       W      = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         apre_n,
  input  logic         spre_n,
  input  logic         cen_n,
  input  logic [W-1:0] jam,
  output logic [W-1:0] value,
  output logic         zero_n
);
  localparam logic [W-1:0] MAX_VAL = W'(max_count(MODE, DIGITS));
  localparam logic [W-1:0] ONE     = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_dec;

  pdc_step #(.MODE(MODE), .DIGITS(DIGITS)) u_step (
    .cur (cnt_q),
    .nxt (cnt_dec)
  );

  // immediate overrides bypass the register; it captures them at each edge
  always_comb begin
    if (!clr_n)       value = MAX_VAL;
    else if (!apre_n) value = jam;
    else              value = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= MAX_VAL;
    else if (!clr_n)  cnt_q <= MAX_VAL;
    else if (!apre_n) cnt_q <= jam;
    else if (!spre_n) cnt_q <= jam;
    else if (!cen_n)  cnt_q <= cnt_dec;
  end

  assign zero_n = !((value == '0) && !cen_n);

  // R1
  generate
    if (MODE == CNT_BIN) begin : g_bin_chk
      count_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && apre_n && spre_n && !cen_n) |=>
          (!clr_n || !apre_n || value == $past(value) - ONE));
    end
  endgenerate

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && apre_n && spre_n && cen_n) |=> (!clr_n || !apre_n || $stable(value)));

  // R3
  clr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(clr_n) && apre_n) |-> (value == MAX_VAL));

  // R4
  apre_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(apre_n) && clr_n && $past(clr_n) && !$past(rst)) |-> (value == $past(jam)));

  // R5
  spre_load_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && apre_n && !spre_n) |=> (!clr_n || !apre_n || value == $past(jam)));

  // R8
  zero_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!zero_n && clr_n && apre_n && spre_n) |=> (!clr_n || !apre_n || value == MAX_VAL));
endmodule

// File: tb/sim_pdc_counter.sv
module sim_pdc_counter;
  import pdc_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr_n = 1'b1, apre_n = 1'b1, spre_n = 1'b1, cen_n = 1'b1;
  logic [7:0] jam = 8'h00;
  logic [7:0] vb, vd, vc;
  logic       zb, zd, zc;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  pdc_counter #(.MODE(CNT_BIN), .DIGITS(2)) u0 (
    .clk(clk), .rst(rst), .clr_n(clr_n), .apre_n(apre_n), .spre_n(spre_n),
    .cen_n(cen_n), .jam(jam), .value(vb), .zero_n(zb));

  pdc_counter #(.MODE(CNT_BCD), .DIGITS(2)) u1 (
    .clk(clk), .rst(rst), .clr_n(clr_n), .apre_n(apre_n), .spre_n(spre_n),
    .cen_n(cen_n), .jam(jam), .value(vd), .zero_n(zd));

  // second stage of a cascade, enabled by the first stage's zero flag
  pdc_counter #(.MODE(CNT_BIN), .DIGITS(2)) u2 (
    .clk(clk), .rst(rst), .clr_n(clr_n), .apre_n(1'b1), .spre_n(1'b1),
    .cen_n(zb), .jam(8'h00), .value(vc), .zero_n(zc));

  // {clr_n,apre_n,spre_n,cen_n}, jam, binary value, decade value, zero_n bin, zero_n dec
  localparam logic [29:0] VEC [13] = '{
    {4'b1111, 8'h00, 8'hFF, 8'h99, 1'b1, 1'b1},  // R2 hold
    {4'b1110, 8'h00, 8'hFE, 8'h98, 1'b1, 1'b1},  // R1 count
    {4'b1100, 8'h10, 8'h10, 8'h10, 1'b1, 1'b1},  // R5 load, enable low
    {4'b1110, 8'h00, 8'h0F, 8'h09, 1'b1, 1'b1},  // R9 borrow
    {4'b1101, 8'h01, 8'h01, 8'h01, 1'b1, 1'b1},  // R5 load, enable high
    {4'b1110, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},  // R7 zero flag
    {4'b1111, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},  // R7 gated by enable
    {4'b1110, 8'h00, 8'hFF, 8'h99, 1'b1, 1'b1},  // R8 wrap
    {4'b1010, 8'h42, 8'h42, 8'h42, 1'b1, 1'b1},  // R4 preset
    {4'b1000, 8'h37, 8'h37, 8'h37, 1'b1, 1'b1},  // R6 preset over clocked
    {4'b0000, 8'h11, 8'hFF, 8'h99, 1'b1, 1'b1},  // R6 clear over all
    {4'b1110, 8'h00, 8'hFE, 8'h98, 1'b1, 1'b1},  // R1 count
    {4'b0110, 8'h00, 8'hFF, 8'h99, 1'b1, 1'b1}   // R3 clear with enable
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fb, fd;
    logic [7:0] d100;
    // R11 reset
    @(negedge clk);
    step();
    chk("R11 reset bin", vb, 8'hFF);
    chk("R11 reset dec", vd, 8'h99);
    rst = 1'b0;

    for (int i = 0; i < 13; i++) begin
      {clr_n, apre_n, spre_n, cen_n} = VEC[i][29:26];
      jam = VEC[i][25:18];
      step();
      chk($sformatf("vec%0d bin", i), vb, VEC[i][17:10]);
      chk($sformatf("vec%0d dec", i), vd, VEC[i][9:2]);
      chk($sformatf("vec%0d zero bin", i), {7'd0, zb}, {7'd0, VEC[i][1]});
      chk($sformatf("vec%0d zero dec", i), {7'd0, zd}, {7'd0, VEC[i][0]});
    end

    // R3 immediate clear, no edge
    clr_n = 1'b1; apre_n = 1'b1; spre_n = 1'b0; cen_n = 1'b1; jam = 8'h05;
    step();
    clr_n = 1'b0; #1;
    chk("R3 immediate bin", vb, 8'hFF);
    chk("R3 immediate dec", vd, 8'h99);
    step(); clr_n = 1'b1; spre_n = 1'b1; #1;
    chk("R3 kept after release", vb, 8'hFF);

    // R4 immediate preset ignoring clocked preset and enable
    step();
    jam = 8'h23; spre_n = 1'b0; cen_n = 1'b0; apre_n = 1'b0; #1;
    chk("R4 immediate bin", vb, 8'h23);
    chk("R4 immediate dec", vd, 8'h23);
    step(); apre_n = 1'b1; spre_n = 1'b1; cen_n = 1'b1; #1;
    chk("R4 kept after release", vd, 8'h23);

    // R7 zero flag follows enable in the same cycle
    spre_n = 1'b0; jam = 8'h00; step(); spre_n = 1'b1; #1;
    chk("R7 enable high", {7'd0, zb}, 8'h01);
    cen_n = 1'b0; #1;
    chk("R7 enable low", {7'd0, zb}, 8'h00);
    cen_n = 1'b1;

    // R11 reset mid-run
    rst = 1'b1; step(); rst = 1'b0;
    chk("R11 reset mid-run", vb, 8'hFF);

    // R8 full period from maximum
    clr_n = 1'b0; step(); clr_n = 1'b1; cen_n = 1'b0;
    fb = 0; fd = 0; d100 = 8'h00;
    for (int n = 1; n <= 256; n++) begin
      step();
      if (!zb && fb == 0) fb = n;
      if (!zd && fd == 0) fd = n;
      if (n == 100) d100 = vd;
    end
    chk("R8 bin edges to zero", 8'(fb), 8'd255);
    chk("R8 dec edges to zero", 8'(fd), 8'd99);
    chk("R8 bin period 256", vb, 8'hFF);
    chk("R8 dec period 100", d100, 8'h99);

    // R9 decade digit order
    cen_n = 1'b1; spre_n = 1'b0; jam = 8'h20; step(); spre_n = 1'b1;
    cen_n = 1'b0; step(); cen_n = 1'b1;
    chk("R9 0x20 to 0x19", vd, 8'h19);

    // R10 invalid digits
    spre_n = 1'b0; jam = 8'hFF; step(); spre_n = 1'b1;
    chk("R10 loaded as given", vd, 8'hFF);
    cen_n = 1'b0;
    for (int n = 0; n < 65; n++) step();
    chk("R10 after 65 edges", vd, 8'hA0);
    step();
    chk("R10 after 66 edges", vd, 8'h99);
    cen_n = 1'b1;

    // R12 cascade
    clr_n = 1'b0; step(); clr_n = 1'b1;
    spre_n = 1'b0; jam = 8'h02; cen_n = 1'b0; step(); spre_n = 1'b1;
    step(); step();
    chk("R12 first stage at zero", vb, 8'h00);
    chk("R12 second stage waits", vc, 8'hFF);
    step();
    chk("R12 first stage wraps", vb, 8'hFF);
    chk("R12 second stage steps once", vc, 8'hFE);
    step();
    chk("R12 second stage holds", vc, 8'hFE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule